// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one SDRAM device from reset until the device can accept normal traffic. For a programmable settling window it keeps clock enable and data mask high and the command inputs idle. It then closes every bank with a single precharge. After that it runs a group of auto-refresh commands and one mode register load, in an order chosen by a strap input. The mode word comes from configuration inputs: read latency, burst ordering, burst length and the write-single option.

The configuration is sampled once, at the end of the settling window. If it holds a reserved or unsupported encoding, the block raises an error flag and issues nothing further. Otherwise it spaces the commands with parameterized idle gaps and raises a ready flag once the last gap has elapsed. A surrounding memory controller waits for ready before it takes over the pins.

Top module: `sdram_boot_seq`

## Requirements
- R1: From reset until the precharge, the pins show clock enable high, data mask high, the idle command ({csN,rasN,casN,weN} = 0111) and an all-zero address and bank. Data mask goes low in the same cycle that ready rises.
- R2: The settling window lasts STABLE_CYC = CLK_MHZ*STABLE_US cycles, with STABLE_US defaulting to 200. The precharge is on the pins in cycle STABLE_CYC+1, counting rising edges after reset is released.
- R3: The precharge is encoded 0010, with address bit AP_BIT set, every other address bit 0 and the bank 0. It is followed by exactly T_RP idle cycles.
- R4: The block issues NUM_REFRESH auto-refresh commands, and never fewer than two. Each is encoded 0001 with address and bank 0, and each is followed by exactly T_RC idle cycles.
- R5: With cfgModeFirst = 0 the refresh group comes before the mode load. With cfgModeFirst = 1 the mode load comes first.
- R6: The mode load is encoded 0000. Its address carries the burst length code on bits 2..0, the burst type on bit 3 (0 sequential, 1 interleaved) and the latency code on bits 6..4. Every other address bit is 0. Bank bit 0 carries cfgWriteSingle and the other bank bits are 0. The mode load is followed by exactly T_MRD idle cycles.
- R7: A configuration is legal only if three conditions all hold. The burst length code is 000, 001, 010, 011 or 111. The code 111 (full page) is paired only with sequential ordering. The latency code is 010 or 011.
- R8: An illegal configuration sets cfgError in cycle STABLE_CYC. From then until reset, no command other than idle appears and ready stays low.
- R9: Ready rises in the cycle after the idle gap of the final command ends, and it stays high. The pins stay idle afterwards.
- R10: The configuration and order inputs are sampled only at the end of the settling window. Later changes have no effect on the sequence or on the mode word.
- R11: A reset at any point returns the pins to idle with ready low and restarts the full sequence from the settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCasLat | input | 3 | Read latency code |
| cfgBurstType | input | 1 | Burst ordering, 1 = interleaved |
| cfgBurstLen | input | 3 | Burst length code |
| cfgWriteSingle | input | 1 | 1 = burst reads with single-location writes |
| cfgModeFirst | input | 1 | 1 = mode load before the refresh group |
| sdCke | output | 1 | Clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | 1 | Data mask |
| sdAddr | output | ADDR_W | Address bus |
| sdBa | output | BA_W | Bank address |
| initDone | output | 1 | Sequence complete |
| cfgError | output | 1 | Reserved configuration detected |

## Verification
The hardest situation to reach is a configuration input that changes after it was sampled. The ports give no sign of when sampling happens, and a wrong design still looks correct whenever the inputs hold steady. The stimulus scrambles every configuration input on each cycle after the end of the settling window, then checks that the mode word on the pins still matches the original setting. A reset raised partway through the refresh group covers the restart path. Random configurations are biased toward legal codes, and directed cases cover the full-page-with-interleave rejection.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRC,
    ST_MRS,
    ST_TMRD,
    ST_READY,
    ST_HALT
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic flagErr;
    logic finish;
  } seqStrobe_t;

  function automatic logic modeLegal(input logic [2:0] casLat,
                                     input logic       burstType,
                                     input logic [2:0] burstLen);
    logic lenOk;
    logic latOk;
    lenOk = (burstLen[2] == 1'b0) || (burstLen == 3'b111 && !burstType);
    latOk = (casLat == 3'd2) || (casLat == 3'd3);
    return lenOk && latOk;
  endfunction

endpackage

// File: rtl/sdram_boot_ctrl.sv
module sdram_boot_ctrl
  import sdram_boot_pkg::*;
#(
  parameter int STABLE_CYC  = 25000,
  parameter int NUM_REFRESH = 2,
  parameter int T_RP        = 3,
  parameter int T_RC        = 8,
  parameter int T_MRD       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgValid,
  input  logic       cfgModeFirst,
  output seqStrobe_t stb
);

  localparam int REF_N    = (NUM_REFRESH < 2) ? 2 : NUM_REFRESH;
  localparam int STB_W    = $clog2(STABLE_CYC + 1);
  localparam int WAIT_MAX = (T_RP > T_RC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                          : ((T_RC > T_MRD) ? T_RC : T_MRD);
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int REF_W    = $clog2(REF_N + 1);

  seqState_e        state, stateNxt;
  logic [STB_W-1:0] stableCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0] refCnt;
  logic             mrsDone;
  logic             modeFirstQ;
  logic             stableLast;
  logic             waitLast;
  logic             isWait;
  logic             refsLeft;

  assign stableLast = (state == ST_STABLE) && (stableCnt == STB_W'(STABLE_CYC - 1));
  assign isWait     = (state == ST_TRP) || (state == ST_TRC) || (state == ST_TMRD);
  assign refsLeft   = (refCnt != REF_W'(REF_N));

  always_comb begin
    waitLast = 1'b0;
    case (state)
      ST_TRP:  waitLast = (waitCnt == WAIT_W'(T_RP - 1));
      ST_TRC:  waitLast = (waitCnt == WAIT_W'(T_RC - 1));
      ST_TMRD: waitLast = (waitCnt == WAIT_W'(T_MRD - 1));
      default: waitLast = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_STABLE: if (stableLast) stateNxt = cfgValid ? ST_PRE : ST_HALT;
      ST_PRE:    stateNxt = ST_TRP;
      ST_TRP:    if (waitLast) stateNxt = modeFirstQ ? ST_MRS : ST_REF;
      ST_REF:    stateNxt = ST_TRC;
      ST_TRC:    if (waitLast) stateNxt = refsLeft ? ST_REF : (mrsDone ? ST_READY : ST_MRS);
      ST_MRS:    stateNxt = ST_TMRD;
      ST_TMRD:   if (waitLast) stateNxt = refsLeft ? ST_REF : ST_READY;
      ST_READY:  stateNxt = ST_READY;
      ST_HALT:   stateNxt = ST_HALT;
      default:   stateNxt = ST_HALT;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.capture  = stableLast;
    stb.flagErr  = stableLast && !cfgValid;
    stb.issuePre = (state == ST_PRE);
    stb.issueRef = (state == ST_REF);
    stb.issueMrs = (state == ST_MRS);
    stb.finish   = (state == ST_READY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_STABLE;
      stableCnt  <= '0;
      waitCnt    <= '0;
      refCnt     <= '0;
      mrsDone    <= 1'b0;
      modeFirstQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_STABLE && !stableLast) stableCnt <= stableCnt + 1'b1;
      waitCnt <= (isWait && !waitLast) ? waitCnt + 1'b1 : '0;
      if (stb.issueRef) refCnt <= refCnt + 1'b1;
      if (stb.issueMrs) mrsDone <= 1'b1;
      if (stb.capture)  modeFirstQ <= cfgModeFirst;
    end
  end

  // R9: ready only once every refresh and the mode load are done
  p_ready_complete_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY) |-> (refCnt == REF_W'(REF_N) && mrsDone));

  // R4: never more refreshes than configured
  p_ref_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueRef |-> refsLeft);

  // R5: mode load position follows the latched order
  p_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueMrs |-> (modeFirstQ ? (refCnt == '0) : !refsLeft));

  // R8: the error halt is permanent until reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT) |=> (state == ST_HALT));

endmodule

// File: rtl/sdram_boot_dp.sv
module sdram_boot_dp
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgWriteSingle,
  output logic              cfgValid,
  output sdCmd_e            cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [BA_W-1:0]   baQ,
  output logic              dqmQ,
  output logic              readyQ,
  output logic              errQ
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [ADDR_W-1:0] modeWord, modeWordQ;
  logic [BA_W-1:0]   modeBa, modeBaQ;

  assign cfgValid = modeLegal(cfgCasLat, cfgBurstType, cfgBurstLen);

  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = cfgBurstLen;
    modeWord[3]   = cfgBurstType;
    modeWord[6:4] = cfgCasLat;
    modeBa        = '0;
    modeBa[0]     = cfgWriteSingle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWordQ <= '0;
      modeBaQ   <= '0;
      cmdQ      <= CMD_NOP;
      addrQ     <= '0;
      baQ       <= '0;
      dqmQ      <= 1'b1;
      readyQ    <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (stb.capture) begin
        modeWordQ <= modeWord;
        modeBaQ   <= modeBa;
      end
      if (stb.flagErr) errQ <= 1'b1;
      if (stb.finish) begin
        readyQ <= 1'b1;
        dqmQ   <= 1'b0;
      end
      if (stb.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= AP_MASK;
        baQ   <= '0;
      end else if (stb.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
        baQ   <= '0;
      end else if (stb.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= modeWordQ;
        baQ   <= modeBaQ;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
        baQ   <= '0;
      end
    end
  end

  // R8: an error keeps the pins idle and ready low
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (cmdQ == CMD_NOP && !readyQ));

  // R6, R7: a mode load on the pins carries only supported latency and zero upper bits
  p_mrs_fields_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_MRS) |-> (addrQ[ADDR_W-1:7] == '0 &&
                           (addrQ[6:4] == 3'd2 || addrQ[6:4] == 3'd3)));

  // R9: ready never falls without reset
  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ);

  // R1: data mask released only together with ready
  p_dqm_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dqmQ != readyQ));

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int STABLE_US   = 200,
  parameter int NUM_REFRESH = 2,
  parameter int T_RP        = 3,
  parameter int T_RC        = 8,
  parameter int T_MRD       = 2,
  parameter int ADDR_W      = 11,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgWriteSingle,
  input  logic              cfgModeFirst,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BA_W-1:0]   sdBa,
  output logic              initDone,
  output logic              cfgError
);

  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;

  seqStrobe_t stb;
  logic       cfgValid;
  sdCmd_e     cmdQ;

  sdram_boot_ctrl #(
    .STABLE_CYC (STABLE_CYC),
    .NUM_REFRESH(NUM_REFRESH),
    .T_RP       (T_RP),
    .T_RC       (T_RC),
    .T_MRD      (T_MRD)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgValid    (cfgValid),
    .cfgModeFirst(cfgModeFirst),
    .stb         (stb)
  );

  sdram_boot_dp #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .AP_BIT(AP_BIT)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cfgCasLat     (cfgCasLat),
    .cfgBurstType  (cfgBurstType),
    .cfgBurstLen   (cfgBurstLen),
    .cfgWriteSingle(cfgWriteSingle),
    .cfgValid      (cfgValid),
    .cmdQ          (cmdQ),
    .addrQ         (sdAddr),
    .baQ           (sdBa),
    .dqmQ          (sdDqm),
    .readyQ        (initDone),
    .errQ          (cfgError)
  );

  assign sdCke = 1'b1;
  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;

endmodule

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;

  localparam int CLK_MHZ = 125;
  localparam int STAB_US = 4;
  localparam int NREF    = 3;
  localparam int TRP     = 3;
  localparam int TRC     = 7;
  localparam int TMRD    = 2;
  localparam int AW      = 11;
  localparam int BW      = 2;
  localparam int APB     = 8;
  localparam int S       = CLK_MHZ * STAB_US;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    cfgCasLat = 3'd2;
  logic          cfgBurstType = 1'b0;
  logic [2:0]    cfgBurstLen = 3'd0;
  logic          cfgWriteSingle = 1'b0;
  logic          cfgModeFirst = 1'b0;
  logic          sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqm, initDone, cfgError;
  logic [AW-1:0] sdAddr;
  logic [BW-1:0] sdBa;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_boot_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STAB_US), .NUM_REFRESH(NREF),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .ADDR_W(AW), .BA_W(BW), .AP_BIT(APB)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgCasLat(cfgCasLat), .cfgBurstType(cfgBurstType),
    .cfgBurstLen(cfgBurstLen), .cfgWriteSingle(cfgWriteSingle), .cfgModeFirst(cfgModeFirst),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdDqm(sdDqm), .sdAddr(sdAddr), .sdBa(sdBa), .initDone(initDone), .cfgError(cfgError)
  );

  localparam int VW = 4 + AW + BW + 4;

  function automatic bit legalCfg(input logic [2:0] cl, input logic bt, input logic [2:0] bl);
    bit lenOk;
    case (bl)
      3'd0, 3'd1, 3'd2, 3'd3: lenOk = 1'b1;
      3'd7:                   lenOk = (bt == 1'b0);
      default:                lenOk = 1'b0;
    endcase
    return lenOk && (cl == 3'd2 || cl == 3'd3);
  endfunction

  function automatic logic [VW-1:0] pack(input logic [3:0] cmd, input logic [AW-1:0] a,
                                         input logic [BW-1:0] b, input logic cke,
                                         input logic dqm, input logic rdy, input logic err);
    return {cmd, a, b, cke, dqm, rdy, err};
  endfunction

  function automatic logic [VW-1:0] pinsNow();
    return pack({sdCsN, sdRasN, sdCasN, sdWeN}, sdAddr, sdBa, sdCke, sdDqm, initDone, cfgError);
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s at t=%0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R11: pins idle, ready low while in reset
    check("R11 reset", pinsNow(), pack(4'b0111, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0));
    rstN = 1'b1;
  endtask

  task automatic runCase(input logic [2:0] cl, input logic bt, input logic [2:0] bl,
                         input logic ws, input logic mf, input bit scramble);
    bit   ok;
    int   pre, first, mrsAt, readyAt, endN;
    int   refAt[NREF];
    logic [AW-1:0] modeA;
    logic [BW-1:0] modeB;
    cfgCasLat = cl; cfgBurstType = bt; cfgBurstLen = bl;
    cfgWriteSingle = ws; cfgModeFirst = mf;
    ok    = legalCfg(cl, bt, bl);
    modeA = '0; modeA[2:0] = bl; modeA[3] = bt; modeA[6:4] = cl;
    modeB = '0; modeB[0] = ws;
    pre   = S + 1;
    first = pre + TRP + 1;
    if (!mf) begin
      for (int i = 0; i < NREF; i++) refAt[i] = first + i * (TRC + 1);
      mrsAt   = first + NREF * (TRC + 1);
      readyAt = mrsAt + TMRD + 1;
    end else begin
      mrsAt = first;
      for (int i = 0; i < NREF; i++) refAt[i] = mrsAt + TMRD + 1 + i * (TRC + 1);
      readyAt = refAt[NREF-1] + TRC + 1;
    end
    endN = ok ? readyAt + 4 : S + 40;
    doReset();
    for (int n = 1; n <= endN; n++) begin
      logic [VW-1:0] exp;
      string tag;
      @(posedge clk);
      @(negedge clk);
      if (!ok) begin
        exp = pack(4'b0111, '0, '0, 1'b1, 1'b1, 1'b0, (n >= S));
        tag = (n >= S) ? "R7 R8 error" : "R1 stable";
      end else if (n == pre) begin
        exp = pack(4'b0010, AW'(1) << APB, '0, 1'b1, 1'b1, 1'b0, 1'b0);
        tag = "R2 R3 precharge";
      end else if (n == mrsAt) begin
        exp = pack(4'b0000, modeA, modeB, 1'b1, 1'b1, 1'b0, 1'b0);
        tag = scramble ? "R10 mode word" : "R6 R7 mode word";
      end else if (n >= readyAt) begin
        exp = pack(4'b0111, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0);
        tag = "R9 ready";
      end else begin
        bit isRef = 1'b0;
        for (int i = 0; i < NREF; i++) if (refAt[i] == n) isRef = 1'b1;
        exp = pack(isRef ? 4'b0001 : 4'b0111, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
        tag = isRef ? "R4 refresh" : ((n < pre) ? "R1 stable" : "R5 gap");
      end
      check(tag, pinsNow(), exp);
      if (scramble && n >= S) begin
        cfgCasLat = 3'($urandom); cfgBurstType = 1'($urandom);
        cfgBurstLen = 3'($urandom); cfgWriteSingle = 1'($urandom);
        cfgModeFirst = 1'($urandom);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failCnt++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed corner cases
    runCase(3'd2, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);  // R5 refresh first
    runCase(3'd3, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0);  // R5 mode first, full page, R6 write-single
    runCase(3'd2, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);  // R7 full page with interleave rejected
    runCase(3'd1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0);  // R7 latency 1 rejected
    runCase(3'd3, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0);  // R7 length code 100 rejected
    runCase(3'd3, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1);  // R10 inputs scrambled after capture
    runCase(3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1);  // R10 order input scrambled too
    // R11: reset in the middle of the refresh group, then a full run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (S + 10) @(negedge clk);
    runCase(3'd3, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
    // constrained random
    for (int k = 0; k < 14; k++) begin
      logic [2:0] cl, bl;
      if ($urandom % 4 != 0) begin
        cl = ($urandom % 2) ? 3'd3 : 3'd2;
        bl = ($urandom % 5 == 4) ? 3'd7 : 3'($urandom % 4);
      end else begin
        cl = 3'($urandom);
        bl = 3'($urandom);
      end
      runCase(cl, 1'($urandom), bl, 1'($urandom), 1'($urandom), 1'($urandom % 3 == 0));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule